// File: doc/BRIEF.md
# USB Host Controller Command and Status Block

This block holds the software-visible run, schedule-enable and doorbell command bits of a USB 2.0-style host controller and builds the 32-bit status word that software polls. Register writes arrive as single-cycle strobes with their data. The schedule engine reports events as single-cycle pulses: schedule advanced, transfer completed, transfer error, port change, frame-list rollover and host-bus error. It also reports a level that flags an empty asynchronous schedule. The block returns the status word, a readback of the command bits and one level-sensitive interrupt request, gated by a six-bit enable mask.

The status bits for the schedules and for the halted condition do not follow the command bits at once. Each is driven by a small state machine that stands in for the engine reaching a safe point. A schedule tracker has the states SCH_OFF, SCH_RISE, SCH_ON and SCH_FALL. Its transitions are: OFF to RISE when the enable is set; RISE to ON when its countdown ends; RISE back to OFF if the enable drops; ON to FALL when the enable clears; FALL to OFF when its countdown ends; FALL back to ON if the enable returns. The halt tracker has the states HLT_HALTED, HLT_RUN and HLT_STOP. Its transitions are: HALTED to RUN when Run/Stop is set; RUN to STOP when Run/Stop clears; STOP to HALTED when its countdown ends; STOP back to RUN if Run/Stop returns. A host-bus error drops Run/Stop in the same clock edge that records it.

Top module: `usbhc_cmdsts`

## Requirements
- R1: After reset the status word is 32'h0000_1000, so only the halted bit is 1. Run/Stop, both schedule enables, the doorbell readback and `irq` are all 0.
- R2: The status word carries these fields. Bit 0 is transfer complete, bit 1 transfer error, bit 2 port change and bit 3 frame rollover. Bit 4 is host system error and bit 5 is async advance. Bit 12 is halted, bit 13 is reclamation, bit 14 is periodic schedule status and bit 15 is async schedule status. Bits 6 to 11 and 16 to 31 always read 0.
- R3: The halted bit reads 0 in every cycle in which Run/Stop reads 1, including the first cycle after the write that sets Run/Stop.
- R4: After Run/Stop clears at clock edge E, the halted bit is still 0 after edge E+HALT_DLY and reads 1 after edge E+HALT_DLY+1. If Run/Stop is set again before then, the halted bit stays 0.
- R5: When the async enable changes at edge E, status bit 15 keeps its old value through edge E+SCHED_DLY and takes the new value after edge E+SCHED_DLY+1. If the enable reverts before then, bit 15 does not change.
- R6: Status bit 14 follows the periodic enable with the same timing and cancellation as R5.
- R7: Writing 1 to the doorbell command bit arms it, and the doorbell readback shows 1. On the next schedule-advanced pulse, status bit 5 sets and the doorbell readback returns to 0. An advance pulse while the doorbell is not armed leaves bit 5 unchanged.
- R8: A host-bus error pulse sets status bit 4 and clears Run/Stop at the same edge. This holds even when a command write setting Run/Stop arrives in the same cycle.
- R9: Bits 0 to 5 are write-1-to-clear through `sts_we`/`sts_wdata`. Writing 0 to a bit leaves it unchanged.
- R10: When an event that sets one of bits 0 to 5 arrives in the same cycle as a write that clears that bit, the bit ends up set.
- R11: `irq` is 1 exactly when some bit among 0 to 5 is 1 and its `irq_mask` bit is also 1. It responds to a mask change in the same cycle.
- R12: The reclamation bit (bit 13) shows the value of `eng_reclaim` from the previous clock edge. It is read-only.
- R13: A command write that sets Run/Stop takes effect while bit 4 is still pending from an earlier host-bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_run | input | 1 | Run/Stop value written |
| cmd_async_en | input | 1 | Async schedule enable value written |
| cmd_per_en | input | 1 | Periodic schedule enable value written |
| cmd_doorbell | input | 1 | 1 arms the async-advance doorbell; 0 has no effect |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 6 | Write-1-to-clear data for status bits 0 to 5 |
| irq_mask | input | 6 | Interrupt enable per status bit 0 to 5 |
| eng_advance | input | 1 | Engine pulse: async schedule advanced |
| eng_xfer_done | input | 1 | Engine pulse: transfer completed with interrupt |
| eng_xfer_err | input | 1 | Engine pulse: transfer error |
| eng_port_chg | input | 1 | Engine pulse: port change |
| eng_frame_roll | input | 1 | Engine pulse: frame list rollover |
| eng_host_err | input | 1 | Engine pulse: host-bus error (parity, master or target abort) |
| eng_reclaim | input | 1 | Engine level: async schedule found empty |
| status | output | 32 | Status word |
| run_out | output | 1 | Run/Stop readback |
| async_en_out | output | 1 | Async enable readback |
| per_en_out | output | 1 | Periodic enable readback |
| doorbell_out | output | 1 | Doorbell readback |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. A host-bus error always leaves Run/Stop low. An armed doorbell drops after an advance. A schedule status bit only moves toward the value its enable held one edge earlier. The halted bit only rises out of the stopping countdown. A status bit never clears without a 1 written to it, and a set event always leaves its bit high. The exact lag counts for halting and for the schedules, and the cancellation of a pending transition, are shown only by the bench's timed scenarios. So are the mask gating of `irq`, the layout of the status word and the readback of the command bits.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;

    localparam int INT_BITS = 6;
    localparam int STS_W    = 32;

    localparam int B_XFER  = 0;
    localparam int B_ERR   = 1;
    localparam int B_PORT  = 2;
    localparam int B_ROLL  = 3;
    localparam int B_HSE   = 4;
    localparam int B_ADV   = 5;
    localparam int B_HALT  = 12;
    localparam int B_RECL  = 13;
    localparam int B_PSTAT = 14;
    localparam int B_ASTAT = 15;

    localparam int NUM_SCHED = 2;
    localparam int SCH_ASYNC = 0;
    localparam int SCH_PER   = 1;

    typedef enum logic [1:0] {
        SCH_OFF  = 2'd0,
        SCH_RISE = 2'd1,
        SCH_ON   = 2'd2,
        SCH_FALL = 2'd3
    } sched_st_t;

    typedef enum logic [1:0] {
        HLT_HALTED = 2'd0,
        HLT_RUN    = 2'd1,
        HLT_STOP   = 2'd2
    } halt_st_t;

endpackage

// File: rtl/usbhc_cmd_reg.sv
module usbhc_cmd_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic cmd_run,
    input  logic cmd_async_en,
    input  logic cmd_per_en,
    input  logic cmd_doorbell,
    input  logic host_err,
    input  logic advance,
    output logic run_q,
    output logic aen_q,
    output logic pen_q,
    output logic door_q
);

    logic run_d, aen_d, pen_d, door_d;

    always_comb begin
        run_d = run_q;
        aen_d = aen_q;
        pen_d = pen_q;
        if (cmd_we) begin
            run_d = cmd_run;
            aen_d = cmd_async_en;
            pen_d = cmd_per_en;
        end
        if (host_err) begin
            run_d = 1'b0;
        end
        door_d = (door_q & ~advance) | (cmd_we & cmd_doorbell);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            aen_q  <= 1'b0;
            pen_q  <= 1'b0;
            door_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            aen_q  <= aen_d;
            pen_q  <= pen_d;
            door_q <= door_d;
        end
    end

    // R8
    hse_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> !run_q);

    // R13
    run_write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_run && !host_err) |=> run_q);

    // R7
    door_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (door_q && advance && !(cmd_we && cmd_doorbell)) |=> !door_q);

endmodule

// File: rtl/usbhc_sched_fsm.sv
module usbhc_sched_fsm
    import usbhc_pkg::*;
#(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sts_o
);

    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    sched_st_t       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SCH_OFF: begin
                if (en_i) begin
                    state_d = SCH_RISE;
                    cnt_d   = LOAD;
                end
            end
            SCH_RISE: begin
                if (!en_i)              state_d = SCH_OFF;
                else if (cnt_q == '0)   state_d = SCH_ON;
                else                    cnt_d   = cnt_q - 1'b1;
            end
            SCH_ON: begin
                if (!en_i) begin
                    state_d = SCH_FALL;
                    cnt_d   = LOAD;
                end
            end
            SCH_FALL: begin
                if (en_i)               state_d = SCH_ON;
                else if (cnt_q == '0)   state_d = SCH_OFF;
                else                    cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = SCH_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SCH_OFF, SCH_RISE: sts_o = 1'b0;
            SCH_ON, SCH_FALL:  sts_o = 1'b1;
            default:           sts_o = 1'b0;
        endcase
    end

    // R5
    sch_rise_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o) |-> $past(en_i));

    // R5
    sch_fall_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o) |-> !$past(en_i));

endmodule

// File: rtl/usbhc_halt_fsm.sv
module usbhc_halt_fsm
    import usbhc_pkg::*;
#(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic halted_o
);

    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    halt_st_t        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HLT_HALTED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HLT_HALTED: begin
                if (run_i) state_d = HLT_RUN;
            end
            HLT_RUN: begin
                if (!run_i) begin
                    state_d = HLT_STOP;
                    cnt_d   = LOAD;
                end
            end
            HLT_STOP: begin
                if (run_i)              state_d = HLT_RUN;
                else if (cnt_q == '0)   state_d = HLT_HALTED;
                else                    cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = HLT_HALTED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            HLT_HALTED:        halted_o = !run_i;
            HLT_RUN, HLT_STOP: halted_o = 1'b0;
            default:           halted_o = 1'b0;
        endcase
    end

    // R4
    halt_only_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_o) |-> ($past(state_q) == HLT_STOP && $past(cnt_q) == '0));

endmodule

// File: rtl/usbhc_int_sts.sv
module usbhc_int_sts
    import usbhc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INT_BITS-1:0] set_i,
    input  logic                clr_we_i,
    input  logic [INT_BITS-1:0] clr_i,
    input  logic [INT_BITS-1:0] mask_i,
    output logic [INT_BITS-1:0] sts_o,
    output logic                irq_o
);

    logic [INT_BITS-1:0] sts_q;
    logic [INT_BITS-1:0] clr_v;

    assign clr_v = clr_we_i ? clr_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_v) | set_i;
        end
    end

    assign sts_o = sts_q;
    assign irq_o = |(sts_q & mask_i);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));

    // R9
    no_clear_without_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sts_q & $past(sts_q) & ~$past(clr_v)) == '0));

endmodule

// File: rtl/usbhc_cmdsts.sv
module usbhc_cmdsts
    import usbhc_pkg::*;
#(
    parameter int SCHED_DLY = 3,
    parameter int HALT_DLY  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_we,
    input  logic                cmd_run,
    input  logic                cmd_async_en,
    input  logic                cmd_per_en,
    input  logic                cmd_doorbell,
    input  logic                sts_we,
    input  logic [INT_BITS-1:0] sts_wdata,
    input  logic [INT_BITS-1:0] irq_mask,
    input  logic                eng_advance,
    input  logic                eng_xfer_done,
    input  logic                eng_xfer_err,
    input  logic                eng_port_chg,
    input  logic                eng_frame_roll,
    input  logic                eng_host_err,
    input  logic                eng_reclaim,
    output logic [STS_W-1:0]    status,
    output logic                run_out,
    output logic                async_en_out,
    output logic                per_en_out,
    output logic                doorbell_out,
    output logic                irq
);

    logic                 run_q, aen_q, pen_q, door_q;
    logic                 halted;
    logic                 recl_q;
    logic [NUM_SCHED-1:0] sch_en;
    logic [NUM_SCHED-1:0] sch_sts;
    logic [INT_BITS-1:0]  set_v;
    logic [INT_BITS-1:0]  int_sts;

    usbhc_cmd_reg u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_run      (cmd_run),
        .cmd_async_en (cmd_async_en),
        .cmd_per_en   (cmd_per_en),
        .cmd_doorbell (cmd_doorbell),
        .host_err     (eng_host_err),
        .advance      (eng_advance),
        .run_q        (run_q),
        .aen_q        (aen_q),
        .pen_q        (pen_q),
        .door_q       (door_q)
    );

    usbhc_halt_fsm #(.DLY(HALT_DLY)) u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .halted_o (halted)
    );

    assign sch_en[SCH_ASYNC] = aen_q;
    assign sch_en[SCH_PER]   = pen_q;

    for (genvar g = 0; g < NUM_SCHED; g++) begin : g_sched
        usbhc_sched_fsm #(.DLY(SCHED_DLY)) u_sch (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (sch_en[g]),
            .sts_o (sch_sts[g])
        );
    end

    always_comb begin
        set_v         = '0;
        set_v[B_XFER] = eng_xfer_done;
        set_v[B_ERR]  = eng_xfer_err;
        set_v[B_PORT] = eng_port_chg;
        set_v[B_ROLL] = eng_frame_roll;
        set_v[B_HSE]  = eng_host_err;
        set_v[B_ADV]  = eng_advance & door_q;
    end

    usbhc_int_sts u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v),
        .clr_we_i (sts_we),
        .clr_i    (sts_wdata),
        .mask_i   (irq_mask),
        .sts_o    (int_sts),
        .irq_o    (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) recl_q <= 1'b0;
        else        recl_q <= eng_reclaim;
    end

    always_comb begin
        status                 = '0;
        status[INT_BITS-1:0]   = int_sts;
        status[B_HALT]         = halted;
        status[B_RECL]         = recl_q;
        status[B_PSTAT]        = sch_sts[SCH_PER];
        status[B_ASTAT]        = sch_sts[SCH_ASYNC];
    end

    assign run_out      = run_q;
    assign async_en_out = aen_q;
    assign per_en_out   = pen_q;
    assign doorbell_out = door_q;

    // R12
    recl_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_RECL] == $past(eng_reclaim));

endmodule

// File: tb/sim_usbhc_cmdsts.sv
`timescale 1ns/1ps
module sim_usbhc_cmdsts;

    localparam int SD = 3;
    localparam int HD = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_we, cmd_run, cmd_async_en, cmd_per_en, cmd_doorbell;
    logic        sts_we;
    logic [5:0]  sts_wdata, irq_mask;
    logic        eng_advance, eng_xfer_done, eng_xfer_err, eng_port_chg;
    logic        eng_frame_roll, eng_host_err, eng_reclaim;
    logic [31:0] status;
    logic        run_out, async_en_out, per_en_out, doorbell_out, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    usbhc_cmdsts #(.SCHED_DLY(SD), .HALT_DLY(HD)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_run(cmd_run), .cmd_async_en(cmd_async_en),
        .cmd_per_en(cmd_per_en), .cmd_doorbell(cmd_doorbell),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .irq_mask(irq_mask),
        .eng_advance(eng_advance), .eng_xfer_done(eng_xfer_done),
        .eng_xfer_err(eng_xfer_err), .eng_port_chg(eng_port_chg),
        .eng_frame_roll(eng_frame_roll), .eng_host_err(eng_host_err),
        .eng_reclaim(eng_reclaim),
        .status(status), .run_out(run_out), .async_en_out(async_en_out),
        .per_en_out(per_en_out), .doorbell_out(doorbell_out), .irq(irq)
    );

    // {events[4:0] = host_err,roll,port,err,done ; clear[5:0] ; mask[5:0] ; expected[5:0] ; irq}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {5'b00001, 6'b000000, 6'b111111, 6'b000001, 1'b1},  // R11 set + mask
        {5'b00110, 6'b000000, 6'b000000, 6'b000111, 1'b0},  // R11 masked off
        {5'b00000, 6'b000010, 6'b000010, 6'b000101, 1'b0},  // R9 clear one bit
        {5'b00000, 6'b000000, 6'b000100, 6'b000101, 1'b1},  // R9 zeros ignored
        {5'b01000, 6'b001000, 6'b001000, 6'b001101, 1'b1},  // R10 set beats clear
        {5'b00000, 6'b111111, 6'b111111, 6'b000000, 1'b0},  // R9 clear all
        {5'b10000, 6'b000000, 6'b010000, 6'b010000, 1'b1},  // R8 host error bit
        {5'b00011, 6'b010000, 6'b000011, 6'b000011, 1'b1},  // R9 / R11
        {5'b00000, 6'b000001, 6'b000001, 6'b000010, 1'b0},  // R11
        {5'b00000, 6'b000010, 6'b000000, 6'b000000, 1'b0}   // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic r, input logic a, input logic p, input logic d);
        cmd_we = 1'b1; cmd_run = r; cmd_async_en = a; cmd_per_en = p; cmd_doorbell = d;
        step(1);
        cmd_we = 1'b0; cmd_doorbell = 1'b0;
    endtask

    task automatic pulse_adv();
        eng_advance = 1'b1;
        step(1);
        eng_advance = 1'b0;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        cmd_we = 0; cmd_run = 0; cmd_async_en = 0; cmd_per_en = 0; cmd_doorbell = 0;
        sts_we = 0; sts_wdata = '0; irq_mask = '0;
        eng_advance = 0; eng_xfer_done = 0; eng_xfer_err = 0; eng_port_chg = 0;
        eng_frame_roll = 0; eng_host_err = 0; eng_reclaim = 0;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 status", status, 32'h0000_1000);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 cmd readback", {28'd0, run_out, async_en_out, per_en_out, doorbell_out}, 32'd0);

        // vector table: R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            {eng_host_err, eng_frame_roll, eng_port_chg, eng_xfer_err, eng_xfer_done} = VEC[i][23:19];
            sts_we    = 1'b1;
            sts_wdata = VEC[i][18:13];
            irq_mask  = VEC[i][12:7];
            step(1);
            chk($sformatf("R9/R10/R11 vec%0d status", i), {26'd0, status[5:0]}, {26'd0, VEC[i][6:1]});
            chk($sformatf("R11 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
            {eng_host_err, eng_frame_roll, eng_port_chg, eng_xfer_err, eng_xfer_done} = '0;
            sts_we = 1'b0; sts_wdata = '0;
        end
        irq_mask = '0;

        // R3 halted clears with run
        do_cmd(1, 0, 0, 0);
        chk("R3 halted with run", {31'd0, status[12]}, 32'd0);
        step(2);

        // R4 halt timing
        do_cmd(0, 0, 0, 0);
        step(HD);
        chk("R4 halted before delay", {31'd0, status[12]}, 32'd0);
        step(1);
        chk("R4 halted after delay", {31'd0, status[12]}, 32'd1);

        // R4 cancel
        do_cmd(1, 0, 0, 0);
        step(2);
        do_cmd(0, 0, 0, 0);
        step(2);
        do_cmd(1, 0, 0, 0);
        step(HD + 3);
        chk("R4 cancel halted", {31'd0, status[12]}, 32'd0);

        // R8 host error overrides run write
        cmd_we = 1'b1; cmd_run = 1'b1; eng_host_err = 1'b1;
        step(1);
        cmd_we = 1'b0; eng_host_err = 1'b0;
        chk("R8 run cleared", {31'd0, run_out}, 32'd0);
        chk("R8 hse bit", {31'd0, status[4]}, 32'd1);

        // R13 run despite pending error
        do_cmd(1, 0, 0, 0);
        chk("R13 run set", {31'd0, run_out}, 32'd1);
        chk("R13 halted low", {31'd0, status[12]}, 32'd0);
        sts_we = 1'b1; sts_wdata = 6'h10;
        step(1);
        sts_we = 1'b0; sts_wdata = '0;
        do_cmd(0, 0, 0, 0);
        step(HD + 2);

        // R5 async schedule lag
        do_cmd(0, 1, 0, 0);
        step(SD);
        chk("R5 async before delay", {31'd0, status[15]}, 32'd0);
        step(1);
        chk("R5 async on", {31'd0, status[15]}, 32'd1);
        do_cmd(0, 0, 0, 0);
        step(SD);
        chk("R5 async still on", {31'd0, status[15]}, 32'd1);
        step(1);
        chk("R5 async off", {31'd0, status[15]}, 32'd0);
        do_cmd(0, 1, 0, 0);
        step(2);
        do_cmd(0, 0, 0, 0);
        step(SD + 3);
        chk("R5 async cancel", {31'd0, status[15]}, 32'd0);

        // R6 periodic schedule lag
        do_cmd(0, 0, 1, 0);
        step(SD);
        chk("R6 periodic before delay", {31'd0, status[14]}, 32'd0);
        step(1);
        chk("R6 periodic on", {31'd0, status[14]}, 32'd1);
        chk("R6 async untouched", {31'd0, status[15]}, 32'd0);
        do_cmd(0, 0, 0, 0);
        step(2);
        do_cmd(0, 0, 1, 0);
        step(SD + 3);
        chk("R6 periodic cancel off", {31'd0, status[14]}, 32'd1);
        do_cmd(0, 0, 0, 0);
        step(SD + 1);
        chk("R6 periodic off", {31'd0, status[14]}, 32'd0);

        // R7 doorbell
        irq_mask = 6'h20;
        pulse_adv();
        chk("R7 advance unarmed", {31'd0, status[5]}, 32'd0);
        do_cmd(0, 0, 0, 1);
        chk("R7 doorbell armed", {31'd0, doorbell_out}, 32'd1);
        pulse_adv();
        chk("R7 advance bit", {31'd0, status[5]}, 32'd1);
        chk("R7 doorbell cleared", {31'd0, doorbell_out}, 32'd0);
        chk("R7 irq from bit5", {31'd0, irq}, 32'd1);
        sts_we = 1'b1; sts_wdata = 6'h20;
        step(1);
        sts_we = 1'b0; sts_wdata = '0;
        chk("R7 bit5 cleared", {31'd0, status[5]}, 32'd0);

        // R12 reclamation
        eng_reclaim = 1'b1;
        step(1);
        chk("R12 reclaim set", {31'd0, status[13]}, 32'd1);
        eng_reclaim = 1'b0;
        step(1);
        chk("R12 reclaim clear", {31'd0, status[13]}, 32'd0);

        // R2 reserved bits stay zero with everything active
        eng_xfer_done = 1; eng_xfer_err = 1; eng_port_chg = 1; eng_frame_roll = 1;
        eng_reclaim = 1;
        do_cmd(1, 1, 1, 0);
        eng_xfer_done = 0; eng_xfer_err = 0; eng_port_chg = 0; eng_frame_roll = 0;
        step(SD + 2);
        chk("R2 reserved zero", status & 32'hFFFF_0FC0, 32'd0);
        chk("R2 field layout", status, 32'h0000_E00F);

        finish_up();
    end

endmodule